// File: doc/BRIEF.md
# DRAM Low-Power Refresh Sequencer

This block sits next to the main DRAM controller and takes over the row strobe, column strobe and write strobe when the memory must be kept alive at low power. Two level-sensitive requests select the mode. The battery-backup request makes the block issue one CAS-before-RAS refresh per long period, with a short RAS-low pulse. CAS stays low between pulses, so only RAS toggles. The self-refresh request makes the block lower CAS first and then RAS, and hold both low. During that time the memory refreshes itself from its own row counter, so no address is driven.

When self-refresh ends, the block raises both strobes for an exit hold time. It then runs a burst of back-to-back CAS-before-RAS cycles, one for each row, before it gives the bus back. Battery-backup exit needs only the exit hold. Ownership of the strobes is shown on `busy`. While `busy` is low, the controller's strobes pass straight through to the memory pins. The block never takes the bus while the controller reports an open page.

All times are counted in clock cycles and set by parameters. The defaults assume a 100 MHz clock: 12500 cycles per backup refresh, 10000 cycles of minimum self-refresh hold, and 1024 burst rows.

Top module: `lpr_seq`

## Requirements
- R1: During and right after reset, `busy` is 0 and the three strobe outputs equal the controller's strobe inputs.
- R2: While `busy` is 0, `ras_n`/`cas_n`/`we_n` equal `mc_ras_n`/`mc_cas_n`/`mc_we_n` in the same cycle. While `busy` is 1, the controller's strobe inputs have no effect on the outputs.
- R3: While `page_open` is 1 and `busy` is 0, a pending request does not take the bus (`busy` stays 0). Once `page_open` falls, the request is accepted on the next clock edge.
- R4: When both requests are high at acceptance, self-refresh is chosen.
- R5: Every RAS-low interval driven by the block has CAS low. The first RAS fall of each session, and the first RAS fall of the burst, is preceded by exactly CAS_LEAD cycles of CAS-low with RAS high. `we_n` is 1 for the whole time `busy` is 1.
- R6: In battery-backup mode, each RAS-low pulse lasts BB_RAS_LOW cycles and consecutive RAS falls are BB_PERIOD cycles apart. CAS stays low throughout.
- R7: In self-refresh, RAS and CAS are both low for at least SR_MIN_HOLD cycles. The hold continues for as long as `sr_req` stays 1. If `sr_req` is already 0, the hold is exactly SR_MIN_HOLD cycles. If `sr_req` falls later, the hold ends on the clock edge after the fall.
- R8: Leaving either low-power mode, both strobes are high for exactly EXIT_HOLD consecutive cycles, directly after the last low-power state.
- R9: After a self-refresh exit, exactly BURST_ROWS refresh pulses follow. Each pulse has BU_RAS_LOW cycles of RAS low, followed by BU_PRE cycles of RAS high with CAS low. `busy` falls right after the last precharge and not earlier.
- R10: A fall of `bbu_req` ends battery-backup mode at the next gap cycle, with no burst. `busy` falls after the exit hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sr_req | input | 1 | Request to enter and remain in self-refresh |
| bbu_req | input | 1 | Request to enter and remain in battery-backup refresh |
| page_open | input | 1 | Main controller currently holds an open row |
| mc_ras_n | input | 1 | Row strobe from the main controller |
| mc_cas_n | input | 1 | Column strobe from the main controller |
| mc_we_n | input | 1 | Write strobe from the main controller |
| busy | output | 1 | Sequencer owns the strobes |
| ras_n | output | 1 | Row strobe to the memory |
| cas_n | output | 1 | Column strobe to the memory |
| we_n | output | 1 | Write strobe to the memory |

## Verification
Some properties hold on every cycle and are checked continuously:
- CAS is low at, and one cycle before, each RAS fall the block drives.
- A self-refresh hold is never cut short while the request is held.
- The exit state keeps both strobes high until its count runs out.
- The row counter never wraps.
- `busy` never falls after a self-refresh until the last row is done.
- The block does not take the bus while a page is open.

Other properties depend on whole sessions, and only the bench's recorded strobe traces can show them. These are the exact cycle counts of leads, pulses, periods and holds, the number of burst pulses, the mode priority, and the absence of a burst after battery-backup exit.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BB_LEAD,
        ST_BB_RAS,
        ST_BB_GAP,
        ST_SR_LEAD,
        ST_SR_HOLD,
        ST_EXIT,
        ST_BU_LEAD,
        ST_BU_RAS,
        ST_BU_PRE
    } lpr_state_e;

endpackage

// File: rtl/lpr_row_ctr.sv
module lpr_row_ctr #(
    parameter int ROWS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int RW = (ROWS > 2) ? $clog2(ROWS) : 1;

    logic [RW-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (clr)
            row_d = '0;
        else if (inc)
            row_d = row_q + RW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign last = (row_q == RW'(ROWS - 1));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !last)
        else $error("row counter stepped past the last row");

endmodule

// File: rtl/lpr_strobe_mux.sv
module lpr_strobe_mux (
    input  logic own,
    input  logic seq_ras_n,
    input  logic seq_cas_n,
    input  logic mc_ras_n,
    input  logic mc_cas_n,
    input  logic mc_we_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);
    always_comb begin
        if (own) begin
            ras_n = seq_ras_n;
            cas_n = seq_cas_n;
            we_n  = 1'b1;
        end else begin
            ras_n = mc_ras_n;
            cas_n = mc_cas_n;
            we_n  = mc_we_n;
        end
    end
endmodule

// File: rtl/lpr_seq.sv
module lpr_seq
    import lpr_pkg::*;
#(
    parameter int CAS_LEAD    = 2,
    parameter int BB_PERIOD   = 12500,
    parameter int BB_RAS_LOW  = 50,
    parameter int SR_MIN_HOLD = 10000,
    parameter int EXIT_HOLD   = 12,
    parameter int BURST_ROWS  = 1024,
    parameter int BU_RAS_LOW  = 6,
    parameter int BU_PRE      = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sr_req,
    input  logic bbu_req,
    input  logic page_open,
    input  logic mc_ras_n,
    input  logic mc_cas_n,
    input  logic mc_we_n,
    output logic busy,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);
    localparam int CNT_W = $clog2(BB_PERIOD + SR_MIN_HOLD + EXIT_HOLD + CAS_LEAD
                                  + BU_RAS_LOW + BU_PRE + 1);
    localparam logic [CNT_W-1:0] LD_LEAD  = CNT_W'(CAS_LEAD - 1);
    localparam logic [CNT_W-1:0] LD_BBRAS = CNT_W'(BB_RAS_LOW - 1);
    localparam logic [CNT_W-1:0] LD_BBGAP = CNT_W'(BB_PERIOD - BB_RAS_LOW - 1);
    localparam logic [CNT_W-1:0] LD_SR    = CNT_W'(SR_MIN_HOLD - 1);
    localparam logic [CNT_W-1:0] LD_EXIT  = CNT_W'(EXIT_HOLD - 1);
    localparam logic [CNT_W-1:0] LD_BURAS = CNT_W'(BU_RAS_LOW - 1);
    localparam logic [CNT_W-1:0] LD_BUPRE = CNT_W'(BU_PRE - 1);

    typedef struct packed {
        lpr_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             from_sr;
    } seq_t;

    seq_t s_d, s_q;
    logic row_clr, row_inc, row_last;
    logic cnt_zero;
    logic seq_ras_n, seq_cas_n;

    assign cnt_zero = (s_q.cnt == '0);

    always_comb begin
        s_d     = s_q;
        row_clr = 1'b0;
        row_inc = 1'b0;
        if (!cnt_zero)
            s_d.cnt = s_q.cnt - CNT_W'(1);
        unique case (s_q.st)
            ST_IDLE: begin
                if (!page_open && sr_req) begin
                    s_d.st = ST_SR_LEAD;  s_d.cnt = LD_LEAD;  s_d.from_sr = 1'b1;
                end else if (!page_open && bbu_req) begin
                    s_d.st = ST_BB_LEAD;  s_d.cnt = LD_LEAD;  s_d.from_sr = 1'b0;
                end
            end
            ST_BB_LEAD: if (cnt_zero) begin
                s_d.st = ST_BB_RAS;  s_d.cnt = LD_BBRAS;
            end
            ST_BB_RAS: if (cnt_zero) begin
                s_d.st = ST_BB_GAP;  s_d.cnt = LD_BBGAP;
            end
            ST_BB_GAP: begin
                if (!bbu_req) begin
                    s_d.st = ST_EXIT;  s_d.cnt = LD_EXIT;
                end else if (cnt_zero) begin
                    s_d.st = ST_BB_RAS;  s_d.cnt = LD_BBRAS;
                end
            end
            ST_SR_LEAD: if (cnt_zero) begin
                s_d.st = ST_SR_HOLD;  s_d.cnt = LD_SR;
            end
            ST_SR_HOLD: if (cnt_zero && !sr_req) begin
                s_d.st = ST_EXIT;  s_d.cnt = LD_EXIT;
            end
            ST_EXIT: if (cnt_zero) begin
                if (s_q.from_sr) begin
                    s_d.st = ST_BU_LEAD;  s_d.cnt = LD_LEAD;
                end else begin
                    s_d.st = ST_IDLE;
                end
            end
            ST_BU_LEAD: if (cnt_zero) begin
                s_d.st  = ST_BU_RAS;  s_d.cnt = LD_BURAS;
                row_clr = 1'b1;
            end
            ST_BU_RAS: if (cnt_zero) begin
                s_d.st = ST_BU_PRE;  s_d.cnt = LD_BUPRE;
            end
            ST_BU_PRE: if (cnt_zero) begin
                if (row_last) begin
                    s_d.st = ST_IDLE;  s_d.from_sr = 1'b0;
                end else begin
                    s_d.st  = ST_BU_RAS;  s_d.cnt = LD_BURAS;
                    row_inc = 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st      <= ST_IDLE;
            s_q.cnt     <= '0;
            s_q.from_sr <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // strobe levels decoded from the registered state only
    always_comb begin
        seq_ras_n = 1'b1;
        seq_cas_n = 1'b1;
        case (s_q.st)
            ST_BB_LEAD, ST_BB_GAP, ST_SR_LEAD, ST_BU_LEAD, ST_BU_PRE:
                seq_cas_n = 1'b0;
            ST_BB_RAS, ST_SR_HOLD, ST_BU_RAS: begin
                seq_ras_n = 1'b0;
                seq_cas_n = 1'b0;
            end
            default: ;
        endcase
    end

    assign busy = (s_q.st != ST_IDLE);

    lpr_row_ctr #(.ROWS(BURST_ROWS)) u_rows (
        .clk(clk), .rst_n(rst_n), .clr(row_clr), .inc(row_inc), .last(row_last)
    );

    lpr_strobe_mux u_mux (
        .own(busy), .seq_ras_n(seq_ras_n), .seq_cas_n(seq_cas_n),
        .mc_ras_n(mc_ras_n), .mc_cas_n(mc_cas_n), .mc_we_n(mc_we_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
    );

    // R5
    cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $fell(ras_n)) |-> (!cas_n && $past(!cas_n)))
        else $error("RAS fell without CAS already low");

    // R3
    page_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && page_open) |=> !busy)
        else $error("bus taken while a page was open");

    // R7
    sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_SR_HOLD && sr_req) |=> (s_q.st == ST_SR_HOLD && !ras_n && !cas_n))
        else $error("self-refresh hold ended while requested");

    // R8
    exit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_EXIT && !cnt_zero) |=> (s_q.st == ST_EXIT && ras_n && cas_n))
        else $error("exit hold cut short");

    // R9
    burst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!$past(s_q.from_sr) || $past(row_last)))
        else $error("bus released before the burst finished");

endmodule

// File: tb/lpr_seq_test.sv
module lpr_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int P_LEAD  = 2;
    localparam int P_BBPER = 20;
    localparam int P_BBLOW = 3;
    localparam int P_SRMIN = 15;
    localparam int P_EXIT  = 4;
    localparam int P_ROWS  = 8;
    localparam int P_BULOW = 2;
    localparam int P_BUPRE = 2;

    // {mc_ras_n, mc_cas_n, mc_we_n} applied while idle; expected outputs alongside
    localparam logic [5:0] VEC [8] = '{
        6'b000_000, 6'b001_001, 6'b010_010, 6'b011_011,
        6'b100_100, 6'b101_101, 6'b110_110, 6'b111_111
    };

    logic clk = 0, rst_n = 0;
    logic sr_req = 0, bbu_req = 0, page_open = 0;
    logic mc_ras_n = 1, mc_cas_n = 1, mc_we_n = 1;
    logic busy, ras_n, cas_n, we_n;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    logic tr_ras [512];
    logic tr_cas [512];
    logic tr_we  [512];
    int   tn = 0;
    logic trace_clr = 0;

    int lead, nruns, hb_cnt, hb_first, hb_last, bad_cbr, we_bad;
    int rlen [64];
    int rstart [64];

    lpr_seq #(
        .CAS_LEAD(P_LEAD), .BB_PERIOD(P_BBPER), .BB_RAS_LOW(P_BBLOW),
        .SR_MIN_HOLD(P_SRMIN), .EXIT_HOLD(P_EXIT), .BURST_ROWS(P_ROWS),
        .BU_RAS_LOW(P_BULOW), .BU_PRE(P_BUPRE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .bbu_req(bbu_req),
        .page_open(page_open), .mc_ras_n(mc_ras_n), .mc_cas_n(mc_cas_n),
        .mc_we_n(mc_we_n), .busy(busy), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (trace_clr) tn <= 0;
        else if (busy && tn < 512) begin
            tr_ras[tn] <= ras_n;
            tr_cas[tn] <= cas_n;
            tr_we[tn]  <= we_n;
            tn <= tn + 1;
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cyc);
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_busy(input logic lvl, input int max, input string req);
        int k = 0;
        while (busy !== lvl && k < max) begin
            @(negedge clk); #1;
            k++;
        end
        check(busy === lvl, req, int'(busy), int'(lvl));
    endtask

    task automatic clear_trace();
        @(negedge clk); trace_clr = 1;
        @(negedge clk); trace_clr = 0;
    endtask

    task automatic scan();
        logic prev = 1'b1;
        lead = 0; nruns = 0; hb_cnt = 0; hb_first = -1; hb_last = -1;
        bad_cbr = 0; we_bad = 0;
        for (int i = 0; i < tn; i++) begin
            if (nruns == 0 && hb_cnt == 0 && tr_ras[i] && !tr_cas[i]) lead++;
            if (!tr_ras[i] && prev && nruns < 64) begin
                rstart[nruns] = i; rlen[nruns] = 0; nruns++;
            end
            if (!tr_ras[i] && nruns > 0) rlen[nruns-1]++;
            if (tr_ras[i] && tr_cas[i]) begin
                if (hb_cnt == 0) hb_first = i;
                hb_last = i; hb_cnt++;
            end
            if (!tr_ras[i] && tr_cas[i]) bad_cbr++;
            if (!tr_we[i]) we_bad++;
            prev = tr_ras[i];
        end
    endtask

    task automatic check_sr_common(input int hold_exp);
        int badb = 0;
        check(lead == P_LEAD, "R5 session lead", lead, P_LEAD);
        check(rlen[0] == hold_exp, "R7 hold length", rlen[0], hold_exp);
        check(hb_cnt == P_EXIT && hb_last - hb_first + 1 == hb_cnt, "R8 exit run", hb_cnt, P_EXIT);
        check(hb_first == rstart[0] + rlen[0], "R8 exit position", hb_first, rstart[0] + rlen[0]);
        check(nruns == 1 + P_ROWS, "R9 burst pulses", nruns - 1, P_ROWS);
        check(rstart[1] - (hb_last + 1) == P_LEAD, "R5 burst lead", rstart[1] - hb_last - 1, P_LEAD);
        for (int j = 1; j < nruns && j < 64; j++) begin
            if (rlen[j] != P_BULOW) badb++;
            if (j > 1 && rstart[j] - rstart[j-1] != P_BULOW + P_BUPRE) badb++;
        end
        check(badb == 0, "R9 burst shape", badb, 0);
        check(tn - (rstart[nruns-1] + rlen[nruns-1]) == P_BUPRE, "R9 release point",
              tn - (rstart[nruns-1] + rlen[nruns-1]), P_BUPRE);
        check(bad_cbr == 0, "R5 CAS low under RAS", bad_cbr, 0);
        check(we_bad == 0, "R5 we_n high while busy", we_bad, 0);
    endtask

    initial begin
        // reset (R1)
        repeat (3) @(negedge clk);
        mc_ras_n = 0; #1;
        check(busy == 0, "R1 busy in reset", int'(busy), 0);
        check(ras_n == 0, "R1 passthrough in reset", int'(ras_n), 0);
        mc_ras_n = 1;
        rst_n = 1;
        @(negedge clk); #1;
        check(busy == 0 && ras_n == 1, "R1 after reset", int'(busy), 0);

        // R2 passthrough vectors
        foreach (VEC[i]) begin
            @(negedge clk);
            {mc_ras_n, mc_cas_n, mc_we_n} = VEC[i][5:3];
            #1;
            check({ras_n, cas_n, we_n} == VEC[i][2:0], "R2 idle passthrough",
                  int'({ras_n, cas_n, we_n}), int'(VEC[i][2:0]));
        end
        {mc_ras_n, mc_cas_n, mc_we_n} = 3'b111;

        // R3: open page defers a self-refresh request
        clear_trace();
        page_open = 1; sr_req = 1; mc_ras_n = 0;
        begin
            int seen = 0;
            repeat (10) begin @(negedge clk); #1; if (busy) seen++; end
            check(seen == 0, "R3 deferred while page open", seen, 0);
        end
        check(ras_n == 0, "R3 controller keeps strobes", int'(ras_n), 0);
        @(negedge clk); page_open = 0; mc_ras_n = 1;
        @(negedge clk); #1;
        check(busy == 1, "R3 accepted after page close", int'(busy), 1);
        sr_req = 0;
        mc_ras_n = 0; mc_we_n = 0;   // R2: ignored while busy
        wait_busy(0, 500, "R9 session end");
        mc_ras_n = 1; mc_we_n = 1;
        @(negedge clk);
        scan();
        check_sr_common(P_SRMIN);

        // R7: request held longer than the minimum
        clear_trace();
        sr_req = 1;
        wait_busy(1, 5, "R7 entry");
        repeat (40) @(negedge clk);
        sr_req = 0;
        wait_busy(0, 500, "R7 session end");
        @(negedge clk);
        scan();
        check_sr_common(40 - P_LEAD + 1);

        // R6 / R10: battery-backup mode
        clear_trace();
        bbu_req = 1; mc_cas_n = 0;
        wait_busy(1, 5, "R6 entry");
        repeat (50) @(negedge clk);
        bbu_req = 0;
        wait_busy(0, 100, "R10 session end");
        mc_cas_n = 1;
        @(negedge clk);
        scan();
        check(lead == P_LEAD, "R5 backup lead", lead, P_LEAD);
        check(nruns == 3, "R6 pulse count", nruns, 3);
        begin
            int bad = 0;
            for (int j = 0; j < nruns && j < 64; j++) begin
                if (rlen[j] != P_BBLOW) bad++;
                if (j > 0 && rstart[j] - rstart[j-1] != P_BBPER) bad++;
            end
            check(bad == 0, "R6 pulse width and period", bad, 0);
        end
        check(hb_cnt == P_EXIT && hb_last - hb_first + 1 == P_EXIT, "R8 backup exit", hb_cnt, P_EXIT);
        check(hb_last == tn - 1, "R10 no burst after backup", hb_last, tn - 1);
        check(tn == 55, "R10 session length", tn, 55);
        check(bad_cbr == 0 && we_bad == 0, "R5 backup strobes", bad_cbr + we_bad, 0);

        // R4: both requests, self-refresh wins
        clear_trace();
        sr_req = 1; bbu_req = 1;
        wait_busy(1, 5, "R4 entry");
        sr_req = 0; bbu_req = 0;
        wait_busy(0, 500, "R4 session end");
        @(negedge clk);
        scan();
        check(rlen[0] == P_SRMIN, "R4 self-refresh chosen", rlen[0], P_SRMIN);
        check(nruns == 1 + P_ROWS, "R4 burst follows", nruns - 1, P_ROWS);

        repeat (3) @(negedge clk); #1;
        check(busy == 0, "R1 idle at end", int'(busy), 0);
        summary();
    end
endmodule